// File: doc/BRIEF.md
# Transmit PHY Bring-Up Sequencer

This block powers up a serial video transmit PHY without software stepping through the procedure. A one-cycle start pulse hands it a pixel-clock value and a PHY type code. It then runs the same choreography twice in a row. Each run sets the prologue bits of an 8-bit PHY control word, moves the colour-conversion path to bypass, and pulses the PHY reset lines. It loads the PHY's device address while a test-clear strobe is held high.

It then sends nine 16-bit register writes to a PHY register-access master over a request/done handshake. Three of the written values come from a PLL table and three from a driver table. Each table is searched with the pixel clock. Afterwards the block powers the transmitter up and toggles the TMDS enable bit. It sets the retention bit for a few PHY types and then waits for PLL lock, with a timeout.

A one-cycle done pulse ends the operation. Two sticky flags report any handshake fault and any lock timeout. The table contents, the device address and the millisecond length are parameters.

Top module: `txphy_bringup`

## Requirements
- R1: After reset, ctrl is 0x00, phy_rst_n is 0, aux_rst is 0, csc_sel is 1, test_clear is 0, dev_addr is 0, acc_req, busy, done, acc_fault and lock_fail are all 0.
- R2: The block accepts start only while busy is low. A start pulse while busy is ignored, so one run produces exactly one done pulse and 18 writes.
- R3: Each of the two passes issues nine writes to these addresses, in this order: 0x06, 0x15, 0x10, 0x13, 0x17, 0x19, 0x09, 0x0E, 0x05. The fixed data is 0x0000 at 0x13, 0x0006 at 0x17 and 0x8000 at 0x05. The PLL table supplies the data for 0x06, 0x15 and 0x10. The driver table supplies the data for 0x19, 0x09 and 0x0E.
- R4: Each table lookup selects the lowest-index entry whose threshold is greater than or equal to the pixel clock. An entry with threshold 0 stops the search, and that entry is used.
- R5: acc_req stays high with acc_addr and acc_data stable until acc_done or acc_err. The request drops for at least one cycle between writes.
- R6: acc_fault is set if a write ends with acc_err, or if neither response arrives within ACK_CYC cycles. The sequence goes on to the next write. A new start clears acc_fault.
- R7: In each pass, phy_rst_n goes high and then low, aux_rst goes high, and dev_addr takes DEV_ADDR while test_clear is 1. test_clear returns to 0. After the first pass, csc_sel is 0.
- R8: ctrl bit6 (TMDS enable) rises only while ctrl bit7 (power-up) is 1, and it rises once per pass. Bit1 (data-enable polarity) ends at 1, bit0, bit2 and bit4 (DDQ power-down) end at 0, and bit3 (TX power-on) ends at 1.
- R9: ctrl bit5 (retention) is set only when the latched type code is 0xB2, 0xC2 or 0xF3. No other code sets it.
- R10: If phy_lock stays low for LOCK_MS*MS_CYC cycles in a pass, lock_fail is set. The run still completes. A new start clears lock_fail.
- R11: done is a single-cycle pulse that comes after the second pass, with busy low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin bring-up (pulse) |
| pix_clk | input | CLK_W | Requested pixel clock, table units |
| phy_type | input | 8 | PHY type code |
| phy_lock | input | 1 | PLL lock status from the PHY |
| acc_done | input | 1 | Register-access write completed |
| acc_err | input | 1 | Register-access write failed |
| acc_req | output | 1 | Register-access write request |
| acc_addr | output | 8 | PHY register address |
| acc_data | output | 16 | PHY register data |
| ctrl | output | 8 | PHY control word |
| phy_rst_n | output | 1 | Main PHY reset line |
| aux_rst | output | 1 | Auxiliary PHY reset, high asserts |
| test_clear | output | 1 | PHY test-clear strobe |
| dev_addr | output | 7 | PHY device address for the access master |
| csc_sel | output | 1 | 1 puts colour conversion in the path, 0 bypasses it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| acc_fault | output | 1 | Sticky handshake fault |
| lock_fail | output | 1 | Sticky lock timeout |

## Verification
The control outputs are registered. A bit changes on the edge that ends the step which owns it, and a write request rises one edge after the sequence reaches that write. Every value is therefore sampled on the falling edge. The falling-edge monitors record rising edges of acc_req, TMDS enable and phy_rst_n in order, so the ordering checks do not depend on exact cycle counts. The responder raises acc_done on the third falling edge of a request, and the block drops the request on the next rising edge. The flags and the final control word are read once done has been seen, because they settle no later than done does. The lock timeout is checked through the start-to-done time, which must exceed two full lock windows.

// File: rtl/txphy_bringup.sv
module txphy_bringup #(
  parameter int CLK_W   = 16,
  parameter int MPLL_N  = 4,
  parameter int DRV_N   = 3,
  parameter int MS_CYC  = 200000,
  parameter int LOCK_MS = 4,
  parameter int ACK_CYC = 1000,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [7:0] RET_A = 8'hB2,
  parameter logic [7:0] RET_B = 8'hC2,
  parameter logic [7:0] RET_C = 8'hF3,
  // element [0] is the rightmost item of each list
  parameter logic [MPLL_N-1:0][CLK_W-1:0] MPLL_THR  = {16'd0, 16'd14850, 16'd7425, 16'd2520},
  parameter logic [MPLL_N-1:0][15:0]      MPLL_CPCE = {16'h0000, 16'h00A0, 16'h0140, 16'h01E0},
  parameter logic [MPLL_N-1:0][15:0]      MPLL_GMP  = {16'h000F, 16'h000A, 16'h0005, 16'h0000},
  parameter logic [MPLL_N-1:0][15:0]      MPLL_CURR = {16'h0008, 16'h0038, 16'h0028, 16'h0018},
  parameter logic [DRV_N-1:0][CLK_W-1:0]  DRV_THR   = {16'd0, 16'd14850, 16'd7425},
  parameter logic [DRV_N-1:0][15:0]       DRV_TERM  = {16'h0000, 16'h0004, 16'h0005},
  parameter logic [DRV_N-1:0][15:0]       DRV_SYM   = {16'h8029, 16'h8009, 16'h800D},
  parameter logic [DRV_N-1:0][15:0]       DRV_VLEV  = {16'h0000, 16'h0273, 16'h0232}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CLK_W-1:0] pix_clk,
  input  logic [7:0]       phy_type,
  input  logic             phy_lock,
  input  logic             acc_done,
  input  logic             acc_err,
  output logic             acc_req,
  output logic [7:0]       acc_addr,
  output logic [15:0]      acc_data,
  output logic [7:0]       ctrl,
  output logic             phy_rst_n,
  output logic             aux_rst,
  output logic             test_clear,
  output logic [6:0]       dev_addr,
  output logic             csc_sel,
  output logic             busy,
  output logic             done,
  output logic             acc_fault,
  output logic             lock_fail
);

  localparam int MI_W     = (MPLL_N > 1) ? $clog2(MPLL_N) : 1;
  localparam int DI_W     = (DRV_N > 1) ? $clog2(DRV_N) : 1;
  localparam int LOCK_CYC = MS_CYC * LOCK_MS;
  localparam int CNT_MAX  = (LOCK_CYC > ACK_CYC) ? LOCK_CYC : ACK_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int N_WR     = 9;

  localparam int B_PWR = 7, B_TMDS = 6, B_RET = 5, B_DDQ = 4, B_TXON = 3, B_POL = 1, B_IF = 0;

  typedef enum logic [4:0] {
    S_IDLE, S_PRO, S_CSC, S_TXOFF, S_DDQ1, S_RREL, S_RASS, S_AUX, S_TC1, S_ADDR, S_TC0,
    S_WR, S_PWR, S_TM0, S_TM1, S_TXON, S_DDQ0, S_RET, S_LOCK, S_FIN
  } step_t;

  step_t            st;
  logic             pass;
  logic [3:0]       widx;
  logic [CNT_W-1:0] cnt;
  logic [CLK_W-1:0] clk_q;
  logic [7:0]       type_q;
  logic [MI_W-1:0]  m_sel;
  logic [DI_W-1:0]  d_sel;
  logic             m_hit, d_hit;

  always_comb begin
    m_sel = MI_W'(MPLL_N - 1);
    m_hit = 1'b0;
    for (int i = 0; i < MPLL_N; i++)
      if (!m_hit && (MPLL_THR[i] == '0 || clk_q <= MPLL_THR[i])) begin
        m_sel = MI_W'(i);
        m_hit = 1'b1;
      end
  end

  always_comb begin
    d_sel = DI_W'(DRV_N - 1);
    d_hit = 1'b0;
    for (int i = 0; i < DRV_N; i++)
      if (!d_hit && (DRV_THR[i] == '0 || clk_q <= DRV_THR[i])) begin
        d_sel = DI_W'(i);
        d_hit = 1'b1;
      end
  end

  always_comb begin
    case (widx)
      4'd0:    begin acc_addr = 8'h06; acc_data = MPLL_CPCE[m_sel]; end
      4'd1:    begin acc_addr = 8'h15; acc_data = MPLL_GMP[m_sel];  end
      4'd2:    begin acc_addr = 8'h10; acc_data = MPLL_CURR[m_sel]; end
      4'd3:    begin acc_addr = 8'h13; acc_data = 16'h0000;         end
      4'd4:    begin acc_addr = 8'h17; acc_data = 16'h0006;         end
      4'd5:    begin acc_addr = 8'h19; acc_data = DRV_TERM[d_sel];  end
      4'd6:    begin acc_addr = 8'h09; acc_data = DRV_SYM[d_sel];   end
      4'd7:    begin acc_addr = 8'h0E; acc_data = DRV_VLEV[d_sel];  end
      default: begin acc_addr = 8'h05; acc_data = 16'h8000;         end
    endcase
  end

  assign busy = (st != S_IDLE);

  wire ret_type  = (type_q == RET_A) || (type_q == RET_B) || (type_q == RET_C);
  wire wr_end    = acc_done || acc_err || (cnt == CNT_W'(ACK_CYC - 1));
  wire lock_end  = phy_lock || (cnt == CNT_W'(LOCK_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      pass       <= 1'b0;
      widx       <= '0;
      cnt        <= '0;
      clk_q      <= '0;
      type_q     <= '0;
      ctrl       <= 8'h00;
      phy_rst_n  <= 1'b0;
      aux_rst    <= 1'b0;
      test_clear <= 1'b0;
      dev_addr   <= '0;
      csc_sel    <= 1'b1;
      acc_req    <= 1'b0;
      done       <= 1'b0;
      acc_fault  <= 1'b0;
      lock_fail  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          clk_q     <= pix_clk;
          type_q    <= phy_type;
          pass      <= 1'b0;
          acc_fault <= 1'b0;
          lock_fail <= 1'b0;
          st        <= S_PRO;
        end
        S_PRO: begin
          ctrl[B_POL]  <= 1'b1;
          ctrl[B_IF]   <= 1'b0;
          ctrl[B_TMDS] <= 1'b0;
          ctrl[B_PWR]  <= 1'b0;
          st           <= S_CSC;
        end
        S_CSC:   begin csc_sel      <= 1'b0;     st <= S_TXOFF; end
        S_TXOFF: begin ctrl[B_TXON] <= 1'b0;     st <= S_DDQ1;  end
        S_DDQ1:  begin ctrl[B_DDQ]  <= 1'b1;     st <= S_RREL;  end
        S_RREL:  begin phy_rst_n    <= 1'b1;     st <= S_RASS;  end
        S_RASS:  begin phy_rst_n    <= 1'b0;     st <= S_AUX;   end
        S_AUX:   begin aux_rst      <= 1'b1;     st <= S_TC1;   end
        S_TC1:   begin test_clear   <= 1'b1;     st <= S_ADDR;  end
        S_ADDR:  begin dev_addr     <= DEV_ADDR; st <= S_TC0;   end
        S_TC0:   begin test_clear   <= 1'b0; widx <= '0; st <= S_WR; end
        S_WR: begin
          if (!acc_req) begin
            acc_req <= 1'b1;
            cnt     <= '0;
          end else if (wr_end) begin
            acc_req <= 1'b0;
            if (acc_err || !acc_done) acc_fault <= 1'b1;
            if (widx == 4'(N_WR - 1)) st <= S_PWR;
            else widx <= widx + 4'd1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PWR:  begin ctrl[B_PWR]  <= 1'b1; st <= S_TM0;  end
        S_TM0:  begin ctrl[B_TMDS] <= 1'b0; st <= S_TM1;  end
        S_TM1:  begin ctrl[B_TMDS] <= 1'b1; st <= S_TXON; end
        S_TXON: begin ctrl[B_TXON] <= 1'b1; st <= S_DDQ0; end
        S_DDQ0: begin ctrl[B_DDQ]  <= 1'b0; st <= S_RET;  end
        S_RET: begin
          if (ret_type) ctrl[B_RET] <= 1'b1;
          cnt <= '0;
          st  <= S_LOCK;
        end
        S_LOCK: begin
          if (lock_end) begin
            if (!phy_lock) lock_fail <= 1'b1;
            if (!pass) begin
              pass <= 1'b1;
              st   <= S_PRO;
            end else begin
              st <= S_FIN;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc_req) && acc_req) |-> ($stable(acc_addr) && $stable(acc_data)));

  assert_req_in_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> busy);

  assert_tmds_after_power_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[B_TMDS]) |-> ctrl[B_PWR]);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ret_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl[B_RET]) |-> ret_type);

endmodule

// File: tb/txphy_bringup_tb.sv
module txphy_bringup_tb_top;

  localparam logic [3:0][15:0] M_THR  = {16'd0, 16'd14850, 16'd7425, 16'd2520};
  localparam logic [3:0][15:0] M_CPCE = {16'h0000, 16'h00A0, 16'h0140, 16'h01E0};
  localparam logic [3:0][15:0] M_GMP  = {16'h000F, 16'h000A, 16'h0005, 16'h0000};
  localparam logic [3:0][15:0] M_CURR = {16'h0008, 16'h0038, 16'h0028, 16'h0018};
  localparam logic [2:0][15:0] D_THR  = {16'd0, 16'd14850, 16'd7425};
  localparam logic [2:0][15:0] D_TERM = {16'h0000, 16'h0004, 16'h0005};
  localparam logic [2:0][15:0] D_SYM  = {16'h8029, 16'h8009, 16'h800D};
  localparam logic [2:0][15:0] D_VLEV = {16'h0000, 16'h0273, 16'h0232};
  localparam int MSC = 50, LMS = 4, ACK = 16, LAT = 3;

  logic clk = 0, rst_n = 0, start = 0, phy_lock = 1, acc_done = 0, acc_err = 0;
  logic [15:0] pix_clk = 0;
  logic [7:0]  phy_type = 0;
  logic acc_req, phy_rst_n, aux_rst, test_clear, csc_sel, busy, done, acc_fault, lock_fail;
  logic [7:0] acc_addr, ctrl;
  logic [15:0] acc_data;
  logic [6:0] dev_addr;

  always #2.5 clk = ~clk;

  txphy_bringup #(.MS_CYC(MSC), .LOCK_MS(LMS), .ACK_CYC(ACK),
    .MPLL_THR(M_THR), .MPLL_CPCE(M_CPCE), .MPLL_GMP(M_GMP), .MPLL_CURR(M_CURR),
    .DRV_THR(D_THR), .DRV_TERM(D_TERM), .DRV_SYM(D_SYM), .DRV_VLEV(D_VLEV)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_clk(pix_clk), .phy_type(phy_type),
    .phy_lock(phy_lock), .acc_done(acc_done), .acc_err(acc_err), .acc_req(acc_req),
    .acc_addr(acc_addr), .acc_data(acc_data), .ctrl(ctrl), .phy_rst_n(phy_rst_n),
    .aux_rst(aux_rst), .test_clear(test_clear), .dev_addr(dev_addr), .csc_sel(csc_sel),
    .busy(busy), .done(done), .acc_fault(acc_fault), .lock_fail(lock_fail));

  int vectors = 0, fails = 0;
  int rmode = 0, err_at = 0;
  int nw, tm_rise, tm_bad, rst_rise, ndone, unstable, rcnt, tc_at_addr, cyc;
  bit addr_seen;
  logic prev_req, prev_tm, prev_rst;
  logic [7:0] prev_a;
  logic [15:0] prev_d;
  logic [7:0]  wa [0:31];
  logic [15:0] wd [0:31];

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (acc_req && !prev_req && nw < 32) begin wa[nw] = acc_addr; wd[nw] = acc_data; nw++; end
    if (acc_req && prev_req && (acc_addr != prev_a || acc_data != prev_d)) unstable++;
    if (ctrl[6] && !prev_tm) begin tm_rise++; if (!ctrl[7]) tm_bad++; end
    if (phy_rst_n && !prev_rst) rst_rise++;
    if (!addr_seen && dev_addr == 7'h69) begin addr_seen = 1; tc_at_addr = int'(test_clear); end
    if (done) ndone++;
    if (acc_req) begin
      rcnt++;
      acc_done = 0; acc_err = 0;
      if (rcnt == LAT && rmode != 2) begin
        if (rmode == 1 && nw - 1 == err_at) acc_err = 1; else acc_done = 1;
      end
    end else begin
      rcnt = 0; acc_done = 0; acc_err = 0;
    end
    prev_req = acc_req; prev_tm = ctrl[6]; prev_rst = phy_rst_n;
    prev_a = acc_addr; prev_d = acc_data;
  end

  task automatic clear_mon();
    nw = 0; tm_rise = 0; tm_bad = 0; rst_rise = 0; ndone = 0; unstable = 0;
    addr_seen = 0; tc_at_addr = -1; cyc = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic launch(input int pc, input int ty, input bit mid_start);
    clear_mon();
    pix_clk = 16'(pc); phy_type = 8'(ty);
    start = 1; @(negedge clk); start = 0;
    if (mid_start) begin repeat (20) @(negedge clk); start = 1; @(negedge clk); start = 0; end
    for (int i = 0; i < 6000 && ndone == 0; i++) @(negedge clk);
    if (ndone == 0) chk("WDOG done", 0, 1);
    repeat (8) @(negedge clk);
  endtask

  function automatic int sel_m(input int pc);
    for (int i = 0; i < 4; i++) if (M_THR[i] == 0 || pc <= int'(M_THR[i])) return i;
    return 3;
  endfunction
  function automatic int sel_d(input int pc);
    for (int i = 0; i < 3; i++) if (D_THR[i] == 0 || pc <= int'(D_THR[i])) return i;
    return 2;
  endfunction

  task automatic check_writes(input int pc, input string tag);
    int mi, di;
    logic [7:0] ea [0:8];
    logic [15:0] ed [0:8];
    mi = sel_m(pc); di = sel_d(pc);
    ea = '{8'h06, 8'h15, 8'h10, 8'h13, 8'h17, 8'h19, 8'h09, 8'h0E, 8'h05};
    ed = '{M_CPCE[mi], M_GMP[mi], M_CURR[mi], 16'h0000, 16'h0006,
           D_TERM[di], D_SYM[di], D_VLEV[di], 16'h8000};
    chk({tag, " R3 write count"}, nw, 18);
    for (int k = 0; k < 18; k++) begin
      chk({tag, " R3 address order"}, int'(wa[k]), int'(ea[k % 9]));
      chk({tag, " R4 table data"}, int'(wd[k]), int'(ed[k % 9]));
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 ctrl", int'(ctrl), 0);
    chk("R1 rst lines", int'({phy_rst_n, aux_rst, test_clear}), 0);
    chk("R1 csc_sel", int'(csc_sel), 1);
    chk("R1 dev_addr", int'(dev_addr), 0);
    chk("R1 status", int'({acc_req, busy, done, acc_fault, lock_fail}), 0);
  endtask

  task automatic t_basic();
    do_reset(); rmode = 0; phy_lock = 1;
    launch(2520, 8'hB2, 0);
    check_writes(2520, "basic");
    chk("R5 stable request", unstable, 0);
    chk("R6 no fault", int'(acc_fault), 0);
    chk("R7 reset pulses", rst_rise, 2);
    chk("R7 final resets", int'({phy_rst_n, aux_rst, test_clear, csc_sel}), 4'b0100);
    chk("R7 addr under test_clear", tc_at_addr, 1);
    chk("R7 dev_addr", int'(dev_addr), 7'h69);
    chk("R8 tmds rises", tm_rise, 2);
    chk("R8 tmds without power", tm_bad, 0);
    chk("R9 ctrl with retention", int'(ctrl), 8'hEA);
    chk("R10 lock ok", int'(lock_fail), 0);
    chk("R11 single done", ndone, 1);
    chk("R11 idle", int'(busy), 0);
  endtask

  task automatic t_lookup();
    do_reset(); rmode = 0; phy_lock = 1;
    launch(7425, 8'h12, 0);  check_writes(7425, "equal");
    launch(10000, 8'h12, 0); check_writes(10000, "mid");
    launch(20000, 8'h12, 0); check_writes(20000, "beyond");
    launch(0, 8'h12, 0);     check_writes(0, "zero");
  endtask

  task automatic t_noret();
    do_reset(); rmode = 0; phy_lock = 1;
    launch(7425, 8'h12, 0);
    chk("R9 ctrl without retention", int'(ctrl), 8'hCA);
    do_reset();
    launch(7425, 8'hF3, 0);
    chk("R9 type F3 retention", int'(ctrl[5]), 1);
    do_reset();
    launch(7425, 8'hC2, 0);
    chk("R9 type C2 retention", int'(ctrl[5]), 1);
  endtask

  task automatic t_err();
    do_reset(); phy_lock = 1;
    rmode = 1; err_at = 4;
    launch(2520, 8'h12, 0);
    chk("R6 error sticky", int'(acc_fault), 1);
    chk("R6 continues", nw, 18);
    chk("R6 done", ndone, 1);
    rmode = 0;
    launch(2520, 8'h12, 0);
    chk("R6 cleared by start", int'(acc_fault), 0);
    rmode = 2;
    launch(2520, 8'h12, 0);
    chk("R6 timeout sticky", int'(acc_fault), 1);
    check_writes(2520, "timeout");
    rmode = 0;
  endtask

  task automatic t_lock();
    do_reset(); rmode = 0; phy_lock = 0;
    launch(2520, 8'h12, 0);
    chk("R10 lock fail", int'(lock_fail), 1);
    chk("R10 done anyway", ndone, 1);
    chk("R10 waited two windows", int'(cyc > 2 * MSC * LMS), 1);
    phy_lock = 1;
    launch(2520, 8'h12, 0);
    chk("R10 cleared by start", int'(lock_fail), 0);
    chk("R10 quick with lock", int'(cyc < 2 * MSC * LMS), 1);
  endtask

  task automatic t_busy_start();
    do_reset(); rmode = 0; phy_lock = 1;
    launch(2520, 8'h12, 1);
    chk("R2 single done", ndone, 1);
    chk("R2 write count", nw, 18);
  endtask

  initial begin
    prev_req = 0; prev_tm = 0; prev_rst = 0; prev_a = 0; prev_d = 0; rcnt = 0;
    clear_mon();
    t_reset();
    t_basic();
    t_lookup();
    t_noret();
    t_err();
    t_lock();
    t_busy_start();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule